// File: doc/BRIEF.md
# Colored Store Buffer with Load Forwarding

This block keeps every store from its allocation until memory has accepted it, and it answers load queries against the stores that are still pending. Each store gets a buffer ID at allocation, in program order. The store then arrives as two independent operations, one carrying the address and one carrying the data, and both name that ID. They may arrive in either order.

A load presents its address, its size and a color. The color is the ID of the youngest store allocated before the load. The buffer looks only at live stores whose age is at or before that color. It picks the youngest older store whose byte range overlaps the load. If that store starts at the same address, is at least as wide as the load and has its data, the buffer forwards the data. Otherwise the load is blocked and must retry. An older store whose address is still unknown also blocks the load.

Retirement marks stores senior, oldest first. Senior stores go to memory strictly in order through a request/acknowledge handshake. A store is offered to memory only when the bus reports idle or the buffer is full. A flush drops every store that is not senior and rewinds allocation to the slot just past the youngest senior store.

Top module: `sb_store_buffer`

## Requirements
- R1: `alloc_gnt` is high exactly when fewer than DEPTH entries are live and `flush` is low. With `alloc_req` high, the store takes ID `alloc_id`. Successive IDs follow program order and are opaque to the user.
- R2: The address op (`sta_*`) and the data op (`std_*`) of one store may arrive in either order. Each fills its half of the entry named by its ID.
- R3: A load compares only against live stores whose ID is at or before its color in program order. Younger stores never affect it.
- R4: Size code 0, 1 and 2 mean 1, 2 and 4 bytes. Among the older stores that overlap the load, the youngest is the candidate. It forwards when its start address equals the load address, its size is at least the load size and its data is present. `ld_data` then holds the low load-size bytes of the store data, zero-extended. Answers are combinational in the cycle of the query.
- R5: `ld_blk` is raised when any older store still lacks its address, or when the candidate fails the forwarding rule of R4. `ld_fwd` and `ld_blk` are never high together.
- R6: With no overlapping older store and no older store of unknown address, or with `ld_vld` low, both `ld_fwd` and `ld_blk` are low.
- R7: Each `ret_vld` pulse marks the oldest non-senior store senior. Senior stores are presented on `mem_*` in allocation order. `mem_req` and its address and data stay stable until `mem_ack`.
- R8: A senior store at the head is requested only while `bus_idle` is high or the buffer is full. `mem_req` rises on the second clock edge after the `ret_vld` that made the head senior.
- R9: At DEPTH live entries allocation stalls. An entry becomes free only on the edge where `mem_req` and `mem_ack` are both high.
- R10: `flush` removes all non-senior stores, keeps senior ones, and makes the next `alloc_id` the ID that followed the youngest senior store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request a new store entry |
| alloc_gnt | output | 1 | Entry available this cycle |
| alloc_id | output | IDW | ID given to the granted store |
| sta_vld | input | 1 | Store address op valid |
| sta_id | input | IDW | Store ID for the address op |
| sta_addr | input | AW | Store byte address |
| sta_size | input | 2 | Store size code |
| std_vld | input | 1 | Store data op valid |
| std_id | input | IDW | Store ID for the data op |
| std_data | input | DW | Store data, low byte at the address |
| ld_vld | input | 1 | Load query valid |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_color | input | IDW | ID of the youngest store older than the load |
| ld_fwd | output | 1 | Data forwarded |
| ld_blk | output | 1 | Load must retry |
| ld_data | output | DW | Forwarded data |
| ret_vld | input | 1 | Retire the oldest non-senior store |
| flush | input | 1 | Discard non-senior stores |
| bus_idle | input | 1 | Memory bus has no other traffic |
| mem_req | output | 1 | Senior store write request |
| mem_addr | output | AW | Write address |
| mem_size | output | 2 | Write size code |
| mem_data | output | DW | Write data |
| mem_ack | input | 1 | Memory accepted the write |

## Verification
Load answers and `alloc_gnt`/`alloc_id` are combinational. The bench reads them 1 ns after driving inputs at a falling edge, with no clock edge in between. Address, data, retire and flush inputs are held across one rising edge, and their effects are read at the following falling edge. After a retire, the bench expects `mem_req` still low at the first falling edge and high at the second. After driving `mem_ack` across one rising edge, it expects the request gone and the entry free at the next falling edge.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_e;

    // size code -> byte count (0:1, 1:2, 2:4, 3:8)
    function automatic logic [3:0] sz_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

endpackage

// File: rtl/sb_ptr_inc.sv
module sb_ptr_inc #(
    parameter int DEPTH = 12,
    localparam int IW   = $clog2(DEPTH),
    localparam int IDW  = IW + 1
) (
    input  logic [IDW-1:0] id_i,
    output logic [IDW-1:0] id_o
);
    // index wraps at DEPTH, the top bit toggles on every wrap
    always_comb begin
        if (id_i[IW-1:0] == IW'(DEPTH - 1)) begin
            id_o = {~id_i[IW], {IW{1'b0}}};
        end else begin
            id_o = {id_i[IW], id_i[IW-1:0] + IW'(1)};
        end
    end
endmodule

// File: rtl/sb_fwd_search.sv
module sb_fwd_search
    import sb_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int IDW  = IW + 1,
    localparam int AGW  = IDW + 1
) (
    input  logic [DEPTH-1:0] e_vld,
    input  logic [DEPTH-1:0] e_aok,
    input  logic [DEPTH-1:0] e_dok,
    input  logic [DEPTH-1:0] e_wrap,
    input  logic [AW-1:0]    e_addr [DEPTH],
    input  logic [1:0]       e_sz   [DEPTH],
    input  logic [DW-1:0]    e_data [DEPTH],
    input  logic             ld_vld,
    input  logic [AW-1:0]    ld_addr,
    input  logic [1:0]       ld_sz,
    input  logic [IDW-1:0]   ld_color,
    output logic             ld_fwd,
    output logic             ld_blk,
    output logic [DW-1:0]    ld_data
);
    localparam logic [AGW-1:0] D_A   = AGW'(DEPTH);
    localparam logic [AGW-1:0] TWO_D = AGW'(2 * DEPTH);
    localparam int             NB    = DW / 8;

    logic [AGW-1:0] age_c;
    logic [AGW-1:0] age_e;
    logic [AGW-1:0] diff;
    logic [AGW-1:0] best_rank;
    logic [IW-1:0]  best;
    logic           hit;
    logic           unk;
    logic [AW:0]    l_end;
    logic [AW:0]    s_end;
    logic           ok_fwd;

    always_comb begin
        age_c     = ld_color[IW] ? AGW'(ld_color[IW-1:0]) + D_A : AGW'(ld_color[IW-1:0]);
        l_end     = {1'b0, ld_addr} + (AW+1)'(sz_bytes(ld_sz));
        best_rank = TWO_D;
        best      = '0;
        hit       = 1'b0;
        unk       = 1'b0;
        age_e     = '0;
        diff      = '0;
        s_end     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            age_e = e_wrap[i] ? AGW'(i) + D_A : AGW'(i);
            diff  = age_c + TWO_D - age_e;
            if (diff >= TWO_D) begin
                diff = diff - TWO_D;
            end
            s_end = {1'b0, e_addr[i]} + (AW+1)'(sz_bytes(e_sz[i]));
            if (e_vld[i] && (diff < D_A)) begin
                if (!e_aok[i]) begin
                    unk = 1'b1;
                end else if (({1'b0, ld_addr} < s_end) &&
                             ({1'b0, e_addr[i]} < l_end) &&
                             (diff < best_rank)) begin
                    best_rank = diff;
                    best      = IW'(i);
                    hit       = 1'b1;
                end
            end
        end

        ok_fwd  = hit && (e_addr[best] == ld_addr) && (ld_sz <= e_sz[best]) && e_dok[best];
        ld_fwd  = 1'b0;
        ld_blk  = 1'b0;
        ld_data = '0;
        if (ld_vld) begin
            if (unk) begin
                ld_blk = 1'b1;
            end else if (hit) begin
                ld_fwd = ok_fwd;
                ld_blk = !ok_fwd;
            end
        end
        if (ld_fwd) begin
            for (int b = 0; b < NB; b++) begin
                if (b < int'(sz_bytes(ld_sz))) begin
                    ld_data[b*8 +: 8] = e_data[best][b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/sb_drain_ctl.sv
module sb_drain_ctl
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_sen,
    input  logic full,
    input  logic bus_idle,
    input  logic mem_ack,
    output logic mem_req,
    output logic pop
);
    drain_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        case (state_q)
            DR_IDLE: begin
                if (head_sen && (bus_idle || full)) begin
                    state_d = DR_BUSY;
                end
            end
            DR_BUSY: begin
                if (mem_ack) begin
                    pop     = 1'b1;
                    state_d = DR_IDLE;
                end
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_req = (state_q == DR_BUSY);
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int IDW  = IW + 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_req,
    output logic           alloc_gnt,
    output logic [IDW-1:0] alloc_id,
    input  logic           sta_vld,
    input  logic [IDW-1:0] sta_id,
    input  logic [AW-1:0]  sta_addr,
    input  logic [1:0]     sta_size,
    input  logic           std_vld,
    input  logic [IDW-1:0] std_id,
    input  logic [DW-1:0]  std_data,
    input  logic           ld_vld,
    input  logic [AW-1:0]  ld_addr,
    input  logic [1:0]     ld_size,
    input  logic [IDW-1:0] ld_color,
    output logic           ld_fwd,
    output logic           ld_blk,
    output logic [DW-1:0]  ld_data,
    input  logic           ret_vld,
    input  logic           flush,
    input  logic           bus_idle,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_data,
    input  logic           mem_ack
);
    typedef struct packed {
        logic          vld;
        logic          sen;
        logic          aok;
        logic          dok;
        logic          wrap;
        logic [AW-1:0] addr;
        logic [1:0]    sz;
        logic [DW-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [IDW-1:0]   head;
        logic [IDW-1:0]   sen;
        logic [IDW-1:0]   tail;
        logic [CW-1:0]    cnt;
    } st_t;

    st_t st_d, st_q;

    logic [IDW-1:0] head_nx, sen_nx, tail_nx;
    logic [IW-1:0]  head_idx, sen_idx, tail_idx, sta_idx, std_idx;
    logic           full, grant, ret_ok, pop, head_sen;
    logic [CW-1:0]  occ;

    logic [DEPTH-1:0] e_vld, e_aok, e_dok, e_wrap;
    logic [AW-1:0]    e_addr [DEPTH];
    logic [1:0]       e_sz   [DEPTH];
    logic [DW-1:0]    e_data [DEPTH];

    assign head_idx = st_q.head[IW-1:0];
    assign sen_idx  = st_q.sen[IW-1:0];
    assign tail_idx = st_q.tail[IW-1:0];
    assign sta_idx  = sta_id[IW-1:0];
    assign std_idx  = std_id[IW-1:0];
    assign occ      = st_q.cnt;
    assign full     = (st_q.cnt == CW'(DEPTH));

    assign alloc_gnt = !full && !flush;
    assign alloc_id  = st_q.tail;
    assign grant     = alloc_req && alloc_gnt;
    assign ret_ok    = ret_vld && (st_q.sen != st_q.tail);
    assign head_sen  = st_q.ent[head_idx].vld && st_q.ent[head_idx].sen;

    sb_ptr_inc #(.DEPTH(DEPTH)) u_inc_head (.id_i(st_q.head), .id_o(head_nx));
    sb_ptr_inc #(.DEPTH(DEPTH)) u_inc_sen  (.id_i(st_q.sen),  .id_o(sen_nx));
    sb_ptr_inc #(.DEPTH(DEPTH)) u_inc_tail (.id_i(st_q.tail), .id_o(tail_nx));

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign e_vld[g]  = st_q.ent[g].vld;
        assign e_aok[g]  = st_q.ent[g].aok;
        assign e_dok[g]  = st_q.ent[g].dok;
        assign e_wrap[g] = st_q.ent[g].wrap;
        assign e_addr[g] = st_q.ent[g].addr;
        assign e_sz[g]   = st_q.ent[g].sz;
        assign e_data[g] = st_q.ent[g].data;
    end

    sb_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
        .e_vld    (e_vld),
        .e_aok    (e_aok),
        .e_dok    (e_dok),
        .e_wrap   (e_wrap),
        .e_addr   (e_addr),
        .e_sz     (e_sz),
        .e_data   (e_data),
        .ld_vld   (ld_vld),
        .ld_addr  (ld_addr),
        .ld_sz    (ld_size),
        .ld_color (ld_color),
        .ld_fwd   (ld_fwd),
        .ld_blk   (ld_blk),
        .ld_data  (ld_data)
    );

    sb_drain_ctl u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_sen (head_sen),
        .full     (full),
        .bus_idle (bus_idle),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .pop      (pop)
    );

    assign mem_addr = st_q.ent[head_idx].addr;
    assign mem_size = st_q.ent[head_idx].sz;
    assign mem_data = st_q.ent[head_idx].data;

    always_comb begin
        st_d = st_q;

        // address half of a store
        if (sta_vld && (int'(sta_idx) < DEPTH)) begin
            if (st_q.ent[sta_idx].vld && !st_q.ent[sta_idx].sen &&
                (st_q.ent[sta_idx].wrap == sta_id[IW])) begin
                st_d.ent[sta_idx].addr = sta_addr;
                st_d.ent[sta_idx].sz   = sta_size;
                st_d.ent[sta_idx].aok  = 1'b1;
            end
        end

        // data half of a store
        if (std_vld && (int'(std_idx) < DEPTH)) begin
            if (st_q.ent[std_idx].vld && !st_q.ent[std_idx].sen &&
                (st_q.ent[std_idx].wrap == std_id[IW])) begin
                st_d.ent[std_idx].data = std_data;
                st_d.ent[std_idx].dok  = 1'b1;
            end
        end

        if (ret_ok) begin
            st_d.ent[sen_idx].sen = 1'b1;
            st_d.sen              = sen_nx;
        end

        if (pop) begin
            st_d.ent[head_idx].vld = 1'b0;
            st_d.ent[head_idx].sen = 1'b0;
            st_d.head              = head_nx;
        end

        if (grant) begin
            st_d.ent[tail_idx].vld  = 1'b1;
            st_d.ent[tail_idx].sen  = 1'b0;
            st_d.ent[tail_idx].aok  = 1'b0;
            st_d.ent[tail_idx].dok  = 1'b0;
            st_d.ent[tail_idx].wrap = st_q.tail[IW];
            st_d.tail               = tail_nx;
        end

        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!st_d.ent[i].sen) begin
                    st_d.ent[i].vld = 1'b0;
                    st_d.ent[i].aok = 1'b0;
                    st_d.ent[i].dok = 1'b0;
                end
            end
            st_d.tail = st_d.sen;
        end

        st_d.cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            st_d.cnt = st_d.cnt + CW'(st_d.ent[i].vld);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sb_store_buffer_chk.sv
module sb_store_buffer_chk #(
    parameter int DEPTH = 12,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_gnt,
    input logic          flush,
    input logic [CW-1:0] occ,
    input logic          full,
    input logic          ld_vld,
    input logic          ld_fwd,
    input logic          ld_blk,
    input logic          bus_idle,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data
);
    AST_FWD_BLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_fwd && ld_blk)); // R5

    AST_QUIET_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld |-> (!ld_fwd && !ld_blk)); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R7

    AST_DRAIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(bus_idle || full)); // R8

    AST_NO_GNT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_gnt); // R9

    AST_FREE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(flush) && (occ < $past(occ))) |-> $past(mem_req && mem_ack)); // R9

    AST_FLUSH_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_gnt); // R10
endmodule

bind sb_store_buffer sb_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_gnt (alloc_gnt),
    .flush     (flush),
    .occ       (occ),
    .full      (full),
    .ld_vld    (ld_vld),
    .ld_fwd    (ld_fwd),
    .ld_blk    (ld_blk),
    .bus_idle  (bus_idle),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
);

// File: tb/tb_sb_store_buffer.sv
`timescale 1ns/1ps
module tb_sb_store_buffer;
    localparam int DEPTH = 12;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int IDW   = $clog2(DEPTH) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           alloc_req = 1'b0;
    logic           alloc_gnt;
    logic [IDW-1:0] alloc_id;
    logic           sta_vld = 1'b0;
    logic [IDW-1:0] sta_id = '0;
    logic [AW-1:0]  sta_addr = '0;
    logic [1:0]     sta_size = '0;
    logic           std_vld = 1'b0;
    logic [IDW-1:0] std_id = '0;
    logic [DW-1:0]  std_data = '0;
    logic           ld_vld = 1'b0;
    logic [AW-1:0]  ld_addr = '0;
    logic [1:0]     ld_size = '0;
    logic [IDW-1:0] ld_color = '0;
    logic           ld_fwd, ld_blk;
    logic [DW-1:0]  ld_data;
    logic           ret_vld = 1'b0;
    logic           flush = 1'b0;
    logic           bus_idle = 1'b0;
    logic           mem_req;
    logic [AW-1:0]  mem_addr;
    logic [1:0]     mem_size;
    logic [DW-1:0]  mem_data;
    logic           mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sb_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_id(alloc_id),
        .sta_vld(sta_vld), .sta_id(sta_id), .sta_addr(sta_addr), .sta_size(sta_size),
        .std_vld(std_vld), .std_id(std_id), .std_data(std_data),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_size(ld_size), .ld_color(ld_color),
        .ld_fwd(ld_fwd), .ld_blk(ld_blk), .ld_data(ld_data),
        .ret_vld(ret_vld), .flush(flush), .bus_idle(bus_idle),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_data(mem_data), .mem_ack(mem_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_alloc(output logic [IDW-1:0] id, input string tag);
        alloc_req = 1'b1;
        #1;
        id = alloc_id;
        chk(alloc_gnt == 1'b1, tag, 32'(alloc_gnt), 32'd1);
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic do_sta(input logic [IDW-1:0] id, input logic [AW-1:0] a, input logic [1:0] sz);
        sta_vld = 1'b1; sta_id = id; sta_addr = a; sta_size = sz;
        @(negedge clk);
        sta_vld = 1'b0;
    endtask

    task automatic do_std(input logic [IDW-1:0] id, input logic [DW-1:0] d);
        std_vld = 1'b1; std_id = id; std_data = d;
        @(negedge clk);
        std_vld = 1'b0;
    endtask

    task automatic do_retire();
        ret_vld = 1'b1;
        @(negedge clk);
        ret_vld = 1'b0;
    endtask

    task automatic ld_q(input logic [AW-1:0] a, input logic [1:0] sz, input logic [IDW-1:0] c,
                        input bit efwd, input bit eblk, input logic [DW-1:0] edata, input string tag);
        ld_vld = 1'b1; ld_addr = a; ld_size = sz; ld_color = c;
        #1;
        chk(ld_fwd == efwd, {tag, " fwd"}, 32'(ld_fwd), 32'(efwd));
        chk(ld_blk == eblk, {tag, " blk"}, 32'(ld_blk), 32'(eblk));
        if (efwd) chk(ld_data == edata, {tag, " data"}, ld_data, edata);
        ld_vld = 1'b0;
    endtask

    task automatic drain_one(input logic [AW-1:0] ea, input string tag);
        for (int k = 0; k < 20 && !mem_req; k++) @(negedge clk);
        #1;
        chk(mem_req == 1'b1, {tag, " req"}, 32'(mem_req), 32'd1);
        chk(mem_addr == ea, {tag, " addr"}, mem_addr, ea);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    logic [IDW-1:0] a0, a1, a2, a3, a4, b0, tmp;

    task automatic t_reset();
        #1;
        chk(alloc_gnt == 1'b1, "R1 reset gnt", 32'(alloc_gnt), 32'd1);
        chk(mem_req == 1'b0, "R7 reset req", 32'(mem_req), 32'd0);
        ld_q(32'h100, 2'd2, '0, 1'b0, 1'b0, '0, "R6 empty buffer");
    endtask

    task automatic t_forward();
        do_alloc(a0, "R1 alloc a0");
        do_std(a0, 32'hAABBCCDD);           // data before address (R2)
        do_sta(a0, 32'h100, 2'd2);
        ld_q(32'h100, 2'd1, a0, 1'b1, 1'b0, 32'h0000CCDD, "R2 R4 half");
        ld_q(32'h100, 2'd2, a0, 1'b1, 1'b0, 32'hAABBCCDD, "R4 word");
        ld_q(32'h100, 2'd0, a0, 1'b1, 1'b0, 32'h000000DD, "R4 byte");
    endtask

    task automatic t_age();
        do_alloc(a1, "R1 alloc a1");
        chk(a1 != a0, "R1 distinct id", 32'(a1), 32'(a0));
        do_sta(a1, 32'h200, 2'd0);
        do_std(a1, 32'h00000055);
        ld_q(32'h200, 2'd0, a0, 1'b0, 1'b0, '0, "R3 younger store ignored");
        ld_q(32'h200, 2'd0, a1, 1'b1, 1'b0, 32'h55, "R3 own color");
    endtask

    task automatic t_youngest();
        do_alloc(a2, "R1 alloc a2");
        do_sta(a2, 32'h100, 2'd2);
        do_std(a2, 32'h11223344);
        ld_q(32'h100, 2'd2, a2, 1'b1, 1'b0, 32'h11223344, "R4 youngest wins");
        ld_q(32'h100, 2'd2, a1, 1'b1, 1'b0, 32'hAABBCCDD, "R3 R4 older color");
    endtask

    task automatic t_block();
        ld_q(32'h102, 2'd0, a2, 1'b0, 1'b1, '0, "R5 start mismatch");
        ld_q(32'h200, 2'd1, a2, 1'b0, 1'b1, '0, "R5 load wider than store");
        do_alloc(a3, "R1 alloc a3");
        do_std(a3, 32'h99);
        ld_q(32'h500, 2'd0, a3, 1'b0, 1'b1, '0, "R5 unknown address");
        do_sta(a3, 32'h300, 2'd2);
        do_alloc(a4, "R1 alloc a4");
        do_sta(a4, 32'h400, 2'd2);
        ld_q(32'h400, 2'd2, a4, 1'b0, 1'b1, '0, "R5 data missing");
        ld_q(32'h500, 2'd0, a4, 1'b0, 1'b0, '0, "R6 no overlap");
    endtask

    task automatic t_drain();
        bus_idle = 1'b0;
        do_retire();                                  // a0 senior
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R8 busy bus holds", 32'(mem_req), 32'd0);
        bus_idle = 1'b1;
        @(negedge clk); #1;
        chk(mem_req == 1'b1, "R7 req a0", 32'(mem_req), 32'd1);
        chk(mem_addr == 32'h100, "R7 addr a0", mem_addr, 32'h100);
        chk(mem_data == 32'hAABBCCDD, "R7 data a0", mem_data, 32'hAABBCCDD);
        @(negedge clk); #1;
        chk(mem_req == 1'b1 && mem_addr == 32'h100, "R7 hold until ack", mem_addr, 32'h100);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        #1;
        chk(mem_req == 1'b0, "R7 req drops after ack", 32'(mem_req), 32'd0);
        do_retire();                                  // a1 senior
        #1;
        chk(mem_req == 1'b0, "R8 first edge", 32'(mem_req), 32'd0);
        @(negedge clk); #1;
        chk(mem_req == 1'b1, "R8 second edge", 32'(mem_req), 32'd1);
        chk(mem_addr == 32'h200, "R7 in order a1", mem_addr, 32'h200);
        chk(mem_size == 2'd0, "R7 size a1", 32'(mem_size), 32'd0);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        bus_idle = 1'b0;
    endtask

    task automatic t_flush();
        do_retire();                                  // a2 senior
        flush = 1'b1;
        #1;
        chk(alloc_gnt == 1'b0, "R10 no grant in flush", 32'(alloc_gnt), 32'd0);
        @(negedge clk);
        flush = 1'b0;
        ld_q(32'h300, 2'd2, a3, 1'b0, 1'b0, '0, "R10 dropped store gone");
        ld_q(32'h100, 2'd2, a2, 1'b1, 1'b0, 32'h11223344, "R10 senior kept");
        do_alloc(b0, "R1 alloc b0");
        chk(b0 == a3, "R10 id rewind", 32'(b0), 32'(a3));
        do_sta(b0, 32'h600, 2'd2);
        do_std(b0, 32'h12345678);
        bus_idle = 1'b1;
        drain_one(32'h100, "R7 drain a2");
        bus_idle = 1'b0;
    endtask

    task automatic t_full();
        for (int n = 0; n < DEPTH - 1; n++) do_alloc(tmp, "R1 fill");
        alloc_req = 1'b1;
        #1;
        chk(alloc_gnt == 1'b0, "R9 stall when full", 32'(alloc_gnt), 32'd0);
        @(negedge clk);
        alloc_req = 1'b0;
        do_retire();                                  // b0 senior, bus busy
        #1;
        chk(mem_req == 1'b0, "R8 full first edge", 32'(mem_req), 32'd0);
        @(negedge clk); #1;
        chk(mem_req == 1'b1, "R8 full drains on busy bus", 32'(mem_req), 32'd1);
        chk(mem_addr == 32'h600, "R7 addr b0", mem_addr, 32'h600);
        chk(alloc_gnt == 1'b0, "R9 not freed before ack", 32'(alloc_gnt), 32'd0);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        #1;
        chk(alloc_gnt == 1'b1, "R9 freed on ack", 32'(alloc_gnt), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_age();
        t_youngest();
        t_block();
        t_drain();
        t_flush();
        t_full();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R7: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule